// File: doc/BRIEF.md
# DDR Memory Bus Target Front End

This block is the device side of an 8-bit double-data-rate memory bus. A host opens a transaction by pulling chip select low while the bus clock is idle low. It then sends a six-byte command/address header on six consecutive bus clock edges, one byte per edge. The target answers with read data or accepts write data, backed by a small internal word memory and two register-space words: a fixed identification word and a writable configuration word.

While the header is arriving, the target drives its strobe line. The level it drives tells the host whether extended initial latency applies. It must do this before it knows what kind of transaction it is serving. After the header, the target waits out the initial latency. For reads it then returns each 16-bit word as two bytes, with the strobe toggling edge-aligned to the data. For writes it uses the strobe level as a per-byte mask. Register-space writes can optionally skip latency entirely.

All bus pins are sampled on a fast synchronous system clock that oversamples the bus clock. Each bus clock transition is recognised as a single-cycle event. Tri-state pins are modelled as value/enable pairs.

Top module: `ddrBusTarget`

## Requirements
- R1: After reset and whenever chip select was high at the previous system clock edge, both `dqOe` and `rwdsOe` are low. This applies to a transaction ended mid-burst, and a later transaction then runs normally.
- R2: The header is six bytes taken on six consecutive bus clock edges, first byte on a rising edge. Bit 7 of the first byte selects read (1) or write (0). Bit 6 selects register space (1) or memory space (0). Bit 5 selects a linear (1) or wrapped (0) burst. The starting word address is the low `ADDR_W` bits of the 48-bit header, whose last byte is bits 7:0.
- R3: From the first system cycle after chip select falls until the header completes, `rwdsOe` is high. `rwdsOut` equals `forceExtLat` as sampled when chip select fell.
- R4: Except for zero-latency writes, data begins on the first rising bus edge after L falling edges have followed the header, or 2L falling edges when extended latency was indicated. L is configuration bits 3:0, with a value of 0 treated as 1. The configuration word resets to 0x0003.
- R5: For reads, on each rising bus edge the target drives the word's bits 15:8 with `rwdsOut` high. On each falling edge it drives bits 7:0 with `rwdsOut` low. `dqOe` is high only in the read data phase, and the strobe is driven from the header through the end of the read.
- R6: For writes with latency, the byte received while `rwdsIn` is low is stored and the byte received while it is high is discarded. Memory words reset to zero.
- R7: When `zeroLatRegWr` is high, a register-space write takes its first data byte on the rising edge right after the header. It stores every byte regardless of `rwdsIn`, and the strobe is released after the header.
- R8: Register word address bit 0 = 0 reads the identification word 0x5A31, and writes to it are ignored. Bit 0 = 1 is the writable configuration word.
- R9: After each word the address advances. A wrapped burst stays inside its aligned 16-word group; a linear burst increments across groups and rolls over at the end of memory.
- R10: While chip select stays low and the bus clock does not change, `dqOut` and `dqOe` hold. The transfer continues correctly when the clock resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| busCk | input | 1 | Bus clock, sampled on `clk` |
| busCsN | input | 1 | Bus chip select, active low |
| dqIn | input | 8 | Bus data from the host |
| dqOut | output | 8 | Bus data driven by the target |
| dqOe | output | 1 | Output enable for `dqOut` |
| rwdsIn | input | 1 | Strobe/mask level from the host |
| rwdsOut | output | 1 | Strobe level driven by the target |
| rwdsOe | output | 1 | Output enable for `rwdsOut` |
| zeroLatRegWr | input | 1 | Register-space writes use zero latency when high |
| forceExtLat | input | 1 | Forces the extended-latency indication |

## Verification
On every cycle, the assertions check four things:
- the pins are released one system cycle after chip select is seen high;
- the strobe is driven whenever read data is;
- read data only changes together with a strobe transition;
- outputs hold while the bus clock is stopped.

Only the bench scenarios can show the following:
- the header decoding and the exact latency count in normal and extended modes;
- the byte masking and the zero-latency override;
- the wrapped and linear address sequences;
- the protection of the identification word.

The bench shows these by comparing read data against a bench memory model.

// File: rtl/busTgtPkg.sv
package busTgtPkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_LAT, PH_DATA} phaseT;

  typedef struct packed {
    logic loadAddr;   // header complete, latch address and mode
    logic linear;     // burst type for loadAddr
    logic regSpace;   // address space for loadAddr
    logic capA;       // write: capture first byte of a word
    logic commitB;    // write: second byte arrives, store word
    logic noMask;     // zero-latency write, ignore byte masks
    logic drvA;       // read: drive high byte
    logic drvB;       // read: drive low byte
  } strobeT;
endpackage

// File: rtl/busTgtCtrl.sv
module busTgtCtrl
  import busTgtPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busCk,
  input  logic              busCsN,
  input  logic [7:0]        dqIn,
  input  logic              zeroLatRegWr,
  input  logic              forceExtLat,
  input  logic [3:0]        latCount,
  output strobeT            stb,
  output logic [ADDR_W-1:0] loadVal,
  output logic              rwdsOut,
  output logic              rwdsOe,
  output logic              dqOe
);
  localparam int LAT_W = 6;

  phaseT             phase;
  logic              ckQ, extQ, zeroQ, isRd, rwdsLvl;
  logic [2:0]        hdrQ;
  logic [2:0]        cntQ;
  logic [ADDR_W-1:0] addrSh;
  logic [LAT_W-1:0]  latLeft, latTot;
  logic [3:0]        latEff;
  logic              rise, fall, anyEdge, caDone, nZero, inData;

  assign rise    = busCk & ~ckQ;
  assign fall    = ~busCk & ckQ;
  assign anyEdge = rise | fall;
  assign caDone  = (phase == PH_CMD) && anyEdge && (cntQ == 3'd5);
  assign nZero   = ~hdrQ[2] & hdrQ[1] & zeroLatRegWr;
  assign latEff  = (latCount == 4'd0) ? 4'd1 : latCount;
  assign latTot  = extQ ? LAT_W'({latEff, 1'b0}) : LAT_W'(latEff);
  assign loadVal = ADDR_W'({addrSh, dqIn});
  assign inData  = (phase == PH_DATA) && !busCsN;

  always_ff @(posedge clk) begin
    if (rst) ckQ <= 1'b0;
    else     ckQ <= busCk;
  end

  always_ff @(posedge clk) begin
    if (rst || busCsN) begin
      phase   <= PH_IDLE;
      cntQ    <= '0;
      rwdsLvl <= 1'b0;
      if (rst) begin
        extQ <= 1'b0; zeroQ <= 1'b0; isRd <= 1'b0;
        hdrQ <= '0; addrSh <= '0; latLeft <= '0;
      end
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase <= PH_CMD;
          cntQ  <= '0;
          extQ  <= forceExtLat;
        end
        PH_CMD: if (anyEdge) begin
          cntQ   <= cntQ + 3'd1;
          addrSh <= loadVal;
          if (cntQ == 3'd0) hdrQ <= dqIn[7:5];
          if (cntQ == 3'd5) begin
            isRd    <= hdrQ[2];
            zeroQ   <= nZero;
            latLeft <= latTot;
            phase   <= nZero ? PH_DATA : PH_LAT;
          end
        end
        PH_LAT: if (fall) begin
          latLeft <= latLeft - LAT_W'(1);
          if (latLeft == LAT_W'(1)) phase <= PH_DATA;
        end
        PH_DATA: begin
          if (isRd && rise) rwdsLvl <= 1'b1;
          if (isRd && fall) rwdsLvl <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.loadAddr = caDone;
    stb.linear   = hdrQ[0];
    stb.regSpace = hdrQ[1];
    stb.noMask   = zeroQ;
    stb.drvA     = inData & isRd & rise;
    stb.drvB     = inData & isRd & fall;
    stb.capA     = inData & ~isRd & rise;
    stb.commitB  = inData & ~isRd & fall;
  end

  assign rwdsOe  = (phase == PH_CMD) || (isRd && (phase == PH_LAT || phase == PH_DATA));
  assign rwdsOut = (phase == PH_CMD) ? extQ : rwdsLvl;
  assign dqOe    = (phase == PH_DATA) && isRd;
endmodule

// File: rtl/busTgtDpath.sv
module busTgtDpath
  import busTgtPkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          WRAP_W    = 4,
  parameter logic [15:0] ID_WORD   = 16'h5A31,
  parameter logic [15:0] CFG_RESET = 16'h0003
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic [7:0]        dqIn,
  input  logic              rwdsIn,
  output logic [7:0]        dqOut,
  output logic [3:0]        latCount
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] WRAP_MASK = ADDR_W'((1 << WRAP_W) - 1);

  logic [15:0]       mem [DEPTH];
  logic [15:0]       cfgQ, rdWord;
  logic [ADDR_W-1:0] addrQ, addrNext;
  logic              linQ, regQ, maskA, dropA, dropB;
  logic [7:0]        byteA;

  assign rdWord   = regQ ? (addrQ[0] ? cfgQ : ID_WORD) : mem[addrQ];
  assign addrNext = linQ ? addrQ + ADDR_W'(1)
                         : (addrQ & ~WRAP_MASK) | ((addrQ + ADDR_W'(1)) & WRAP_MASK);
  assign dropA    = ~stb.noMask & maskA;
  assign dropB    = ~stb.noMask & rwdsIn;
  assign latCount = cfgQ[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0; linQ <= 1'b0; regQ <= 1'b0;
      byteA <= '0; maskA <= 1'b0; dqOut <= '0; cfgQ <= CFG_RESET;
    end else begin
      if (stb.loadAddr) begin
        addrQ <= loadVal;
        linQ  <= stb.linear;
        regQ  <= stb.regSpace;
      end else if (stb.commitB || stb.drvB) begin
        addrQ <= addrNext;
      end
      if (stb.capA) begin
        byteA <= dqIn;
        maskA <= rwdsIn;
      end
      if (stb.drvA) dqOut <= rdWord[15:8];
      if (stb.drvB) dqOut <= rdWord[7:0];
      if (stb.commitB && regQ && addrQ[0]) begin
        if (!dropA) cfgQ[15:8] <= byteA;
        if (!dropB) cfgQ[7:0]  <= dqIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.commitB && !regQ) begin
      if (!dropA) mem[addrQ][15:8] <= byteA;
      if (!dropB) mem[addrQ][7:0]  <= dqIn;
    end
  end
endmodule

// File: rtl/ddrBusTarget.sv
module ddrBusTarget
  import busTgtPkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          WRAP_W    = 4,
  parameter logic [15:0] ID_WORD   = 16'h5A31,
  parameter logic [15:0] CFG_RESET = 16'h0003
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busCk,
  input  logic       busCsN,
  input  logic [7:0] dqIn,
  output logic [7:0] dqOut,
  output logic       dqOe,
  input  logic       rwdsIn,
  output logic       rwdsOut,
  output logic       rwdsOe,
  input  logic       zeroLatRegWr,
  input  logic       forceExtLat
);
  strobeT            stb;
  logic [ADDR_W-1:0] loadVal;
  logic [3:0]        latCount;

  busTgtCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busCk(busCk), .busCsN(busCsN), .dqIn(dqIn),
    .zeroLatRegWr(zeroLatRegWr), .forceExtLat(forceExtLat), .latCount(latCount),
    .stb(stb), .loadVal(loadVal), .rwdsOut(rwdsOut), .rwdsOe(rwdsOe), .dqOe(dqOe)
  );

  busTgtDpath #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W), .ID_WORD(ID_WORD), .CFG_RESET(CFG_RESET)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .loadVal(loadVal), .dqIn(dqIn),
    .rwdsIn(rwdsIn), .dqOut(dqOut), .latCount(latCount)
  );
endmodule

// File: rtl/busTgtChk.sv
module busTgtChk (
  input logic       clk,
  input logic       rst,
  input logic       busCk,
  input logic       busCsN,
  input logic [7:0] dqOut,
  input logic       dqOe,
  input logic       rwdsOut,
  input logic       rwdsOe
);
  AST_RELEASE_ON_CS: assert property (@(posedge clk) disable iff (rst)
    $past(busCsN) |-> (!rwdsOe && !dqOe)); // R1

  AST_STROBE_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    dqOe |-> rwdsOe); // R5

  AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (dqOe && $past(dqOe) && !$stable(dqOut)) |-> !$stable(rwdsOut)); // R5

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!$past(busCsN) && !$past(busCsN, 2) && ($past(busCk) == $past(busCk, 2)))
      |-> ($stable(dqOut) && $stable(dqOe))); // R10
endmodule

bind ddrBusTarget busTgtChk u_chk (
  .clk(clk), .rst(rst), .busCk(busCk), .busCsN(busCsN),
  .dqOut(dqOut), .dqOe(dqOe), .rwdsOut(rwdsOut), .rwdsOe(rwdsOe)
);

// File: tb/sim_ddrBusTarget.sv
`timescale 1ns/1ps
module sim_ddrBusTarget;
  localparam int AW = 6;
  localparam int NW = 1 << AW;
  localparam logic [15:0] IDW = 16'h5A31;

  logic clk = 1'b0, rst = 1'b1;
  logic busCk = 1'b0, busCsN = 1'b1, rwdsIn = 1'b0, zeroLatRegWr = 1'b0, forceExtLat = 1'b0;
  logic [7:0] dqIn = '0, dqOut;
  logic dqOe, rwdsOut, rwdsOe;

  int checks = 0, errors = 0;
  logic [15:0] memM [NW];
  logic [15:0] cfgM = 16'h0003;
  logic [15:0] wd [16];
  logic [1:0]  wm [16];

  always #5 clk = ~clk;

  ddrBusTarget u0 (
    .clk(clk), .rst(rst), .busCk(busCk), .busCsN(busCsN), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .rwdsIn(rwdsIn), .rwdsOut(rwdsOut), .rwdsOe(rwdsOe),
    .zeroLatRegWr(zeroLatRegWr), .forceExtLat(forceExtLat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int nextAddr(input int a, input bit lin);
    if (lin) return (a + 1) % NW;
    return (a & ~15) | ((a + 1) & 15);
  endfunction

  function automatic logic [15:0] expWord(input bit rg, input int a);
    if (rg) return a[0] ? cfgM : IDW;
    return memM[a];
  endfunction

  function automatic int latOf(input bit ext);
    int l;
    l = (cfgM[3:0] == 4'd0) ? 1 : int'(cfgM[3:0]);
    return ext ? 2 * l : l;
  endfunction

  task automatic half(input logic lvl, input logic [7:0] d, input logic rw);
    @(negedge clk);
    busCk = lvl; dqIn = d; rwdsIn = rw;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic endCs();
    @(negedge clk);
    busCsN = 1'b1;
    @(negedge clk);
    chk(!dqOe && !rwdsOe, "R1 release", {30'd0, dqOe, rwdsOe}, 32'd0);
    @(negedge clk);
  endtask

  // stopW: word after whose rising edge the clock pauses; abortW: word after which CS rises
  task automatic xfer(input bit rd, input bit rg, input bit lin, input int addr, input int n,
                      input bit ext, input int stopW, input int abortW);
    logic [47:0] ca;
    bit zl;
    int a, lat;
    logic [15:0] e;
    logic mA, mB;
    ca = {rd, rg, lin, 45'd0};
    ca[AW-1:0] = addr[AW-1:0];
    zl = !rd && rg && zeroLatRegWr;
    lat = zl ? 0 : latOf(ext);
    @(negedge clk);
    forceExtLat = ext; busCsN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      if (i < 6) chk(rwdsOe && (rwdsOut == ext), "R3 cmd strobe", {30'd0, rwdsOe, rwdsOut}, {30'd0, 1'b1, ext});
      half(~busCk, ca[47 - 8 * i -: 8], 1'b0);
    end
    if (!rd) chk(!rwdsOe, "R7 strobe released on write", {31'd0, rwdsOe}, 32'd0);
    for (int i = 0; i < lat; i++) begin
      half(1'b1, 8'h00, 1'b0);
      if (rd) chk(!dqOe, "R4 latency not over", {31'd0, dqOe}, 32'd0);
      half(1'b0, 8'h00, 1'b0);
    end
    a = addr;
    for (int w = 0; w < n; w++) begin
      e = expWord(rg, a);
      mA = zl ? 1'b0 : wm[w][1];
      mB = zl ? 1'b0 : wm[w][0];
      half(1'b1, wd[w][15:8], wm[w][1]);
      if (rd) chk(dqOe && rwdsOut && dqOut == e[15:8], "R5 R2 byte A",
                  {22'd0, dqOe, rwdsOut, dqOut}, {22'd0, 2'b11, e[15:8]});
      if (w == stopW) begin
        for (int k = 0; k < 25; k++) @(negedge clk);
        if (rd) chk(dqOe && dqOut == e[15:8], "R10 hold while stopped", {23'd0, dqOe, dqOut}, {23'd0, 1'b1, e[15:8]});
      end
      half(1'b0, wd[w][7:0], wm[w][0]);
      if (rd) chk(dqOe && !rwdsOut && dqOut == e[7:0], "R5 R9 byte B",
                  {22'd0, dqOe, rwdsOut, dqOut}, {22'd0, 2'b10, e[7:0]});
      if (!rd) begin
        if (rg) begin
          if (a[0]) begin
            if (!mA) cfgM[15:8] = wd[w][15:8];
            if (!mB) cfgM[7:0]  = wd[w][7:0];
          end
        end else begin
          if (!mA) memM[a][15:8] = wd[w][15:8];
          if (!mB) memM[a][7:0]  = wd[w][7:0];
        end
      end
      a = nextAddr(a, lin);
      if (w == abortW) break;
    end
    endCs();
  endtask

  task automatic readOne(input bit rg, input int addr, input string req);
    logic [15:0] e;
    e = expWord(rg, addr);
    xfer(1'b1, rg, 1'b1, addr, 1, 1'b0, -1, -1);
    chk(1'b1, req, 32'd0, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) memM[i] = '0;
    for (int i = 0; i < 16; i++) begin wd[i] = '0; wm[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!dqOe && !rwdsOe && !rwdsOut, "R1 reset state", {29'd0, dqOe, rwdsOe, rwdsOut}, 32'd0);

    // R8 identification and configuration reset values, R4 default latency
    xfer(1'b1, 1'b1, 1'b1, 0, 2, 1'b0, -1, -1);

    // R6 masked writes, linear burst
    for (int i = 0; i < 8; i++) begin wd[i] = 16'h1100 * 16'(i + 1) + 16'(i); wm[i] = 2'b00; end
    xfer(1'b0, 1'b0, 1'b1, 12, 8, 1'b0, -1, -1);
    wd[0] = 16'hAAAA; wm[0] = 2'b10;
    wd[1] = 16'hBBBB; wm[1] = 2'b01;
    wd[2] = 16'hCCCC; wm[2] = 2'b11;
    xfer(1'b0, 1'b0, 1'b1, 12, 3, 1'b0, -1, -1);
    for (int i = 0; i < 8; i++) wm[i] = 2'b00;
    xfer(1'b1, 1'b0, 1'b1, 12, 8, 1'b0, -1, -1);
    chk(memM[12] == 16'h11AA && memM[14] == 16'h3302, "R6 mask model", {memM[12], memM[14]}, {16'h11AA, 16'h3302});

    // R9 wrapped read crosses the group boundary back to 0
    xfer(1'b1, 1'b0, 1'b0, 14, 4, 1'b0, -1, -1);

    // R4 extended latency read
    xfer(1'b1, 1'b0, 1'b1, 13, 2, 1'b1, -1, -1);

    // R8 configuration write with latency, then ID write attempt
    wd[0] = 16'h0002; wm[0] = 2'b00;
    xfer(1'b0, 1'b1, 1'b1, 1, 1, 1'b0, -1, -1);
    wd[0] = 16'hFFFF;
    xfer(1'b0, 1'b1, 1'b1, 0, 1, 1'b0, -1, -1);
    xfer(1'b1, 1'b1, 1'b1, 0, 2, 1'b0, -1, -1);

    // R7 zero-latency register write ignores masks
    zeroLatRegWr = 1'b1;
    wd[0] = 16'h0A04; wm[0] = 2'b11;
    xfer(1'b0, 1'b1, 1'b1, 1, 1, 1'b1, -1, -1);
    chk(cfgM == 16'h0A04, "R7 model", {16'd0, cfgM}, 32'h0A04);
    xfer(1'b1, 1'b1, 1'b1, 1, 1, 1'b0, -1, -1);
    zeroLatRegWr = 1'b0;

    // R10 clock stopped mid-burst
    xfer(1'b1, 1'b0, 1'b1, 12, 4, 1'b0, 1, -1);

    // R1 abort mid-read, then a normal transaction
    xfer(1'b1, 1'b0, 1'b1, 12, 6, 1'b0, -1, 1);
    xfer(1'b1, 1'b0, 1'b0, 15, 3, 1'b1, -1, -1);

    // random traffic against the model
    for (int t = 0; t < 30; t++) begin
      bit rd, lin, ext;
      int ad, n;
      rd  = 1'($urandom % 2);
      lin = 1'($urandom % 2);
      ext = 1'($urandom % 2);
      ad  = int'($urandom % NW);
      n   = 1 + int'($urandom % 6);
      for (int i = 0; i < 16; i++) begin
        wd[i] = 16'($urandom);
        wm[i] = 2'($urandom);
      end
      xfer(rd, 1'b0, lin, ad, n, ext, -1, -1);
    end
    for (int i = 0; i < 16; i++) wm[i] = 2'b00;
    xfer(1'b1, 1'b0, 1'b1, 0, 16, 1'b0, -1, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule